// File: doc/BRIEF.md
# CSMA/CD Transmit Access Controller

This block decides when one station may drive a shared medium. A pending transmit request is held back while the medium carries another station's traffic. Transmission is granted on the first clock on which the medium is seen idle. While the station transmits, the block watches a collision flag. A collision withdraws the grant in the same cycle. The block then sits out a pseudo-random number of slot times and senses the medium again before it retries.

The random wait comes from a 16-bit shift register that is stepped once for every collision. Its value is cut down to a window that doubles with each consecutive collision, up to a cap. A clean completion, signalled by `tx_done`, ends the attempt series with a one-cycle success pulse. Too many consecutive collisions end it with a one-cycle failure pulse. The slot length, attempt limit, window cap and shift-register seed are parameters. Stations that share a medium should be built with different seeds. The serialiser, the data path and the analogue collision detector stay outside this block.

Top module: `csma_tx_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_enable`, `success` and `failure` are all low.
- R2: In idle, a `tx_request` sampled at a rising edge while `carrier_sense` is low raises `tx_enable` after that edge.
- R3: A request sampled while `carrier_sense` is high keeps `tx_enable` low for as long as the carrier stays high. `tx_enable` rises after the first edge at which the carrier is sampled low. A grant never begins unless the carrier was low at the edge before it.
- R4: While `tx_enable` is high, raising `collision` drops `tx_enable` in the same cycle, without waiting for a clock edge. `tx_enable` stays low after the next edge.
- R5: On the n-th consecutive collision (n below MAX_ATTEMPTS), the shift register first advances once: its new bit 0 is bit15^bit13^bit12^bit10 and the other bits shift up by one, starting from SEED (default 16'hACE1). The backoff length is k = value & (2^min(n,BACKOFF_CAP) − 1) slots. With the carrier free, `tx_enable` rises again after the (k·SLOT_CYCLES + 2)-th rising edge, counting the edge that samples the collision as the first. `tx_enable` is low throughout the backoff.
- R6: If `carrier_sense` is high when the backoff ends, the block defers as in R3 and only then transmits.
- R7: The MAX_ATTEMPTS-th consecutive collision (16 by default) also advances the shift register. It then raises `failure` for exactly one cycle after the collision edge, does not retry, returns to idle and clears the collision count.
- R8: `tx_done` sampled during a grant with `collision` low raises `success` for exactly one cycle after that edge, ends the grant and clears the collision count, so the next collision uses n = 1.
- R9: If `collision` and `tx_done` are sampled high at the same edge, the collision wins: no success pulse, and the backoff of R5 follows.
- R10: `tx_done` outside a grant is ignored: no success pulse, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_request | input | 1 | Frame waiting to be sent; sampled in idle |
| tx_done | input | 1 | Frame fully sent |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision seen on the medium |
| tx_enable | output | 1 | Station may drive the medium |
| success | output | 1 | One-cycle pulse: frame sent cleanly |
| failure | output | 1 | One-cycle pulse: attempt limit reached |

## Verification
The bench starts requests onto a free medium and onto a busy one. This separates an immediate grant from deferral and shows that the grant waits for the carrier to fall. It then applies runs of consecutive collisions and times each retry against its own model of the shift register. These runs separate a correct window width per attempt, a correct register stepping and a correct slot length; any one of them being wrong shifts the retry edge. Further cases cover a busy carrier at the end of backoff, collision together with completion, completion while idle, and the full run up to give-up followed by a fresh request. These show the counter clearing and the priority rules.

// File: rtl/csma_pkg.sv
package csma_pkg;

  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT,
    ST_BACKOFF
  } tx_state_e;

  // One step of the backoff shift register: shift up, feedback into bit 0.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] cur);
    logic fb;
    fb = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
    return {cur[LFSR_W-2:0], fb};
  endfunction

  // Low-order ones mask whose width grows with the attempt number, capped.
  function automatic logic [LFSR_W-1:0] window_mask(input int unsigned attempts,
                                                    input int unsigned cap);
    int unsigned e;
    e = (attempts < cap) ? attempts : cap;
    return LFSR_W'((32'd1 << e) - 32'd1);
  endfunction

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  output logic [15:0] draw
);
  import csma_pkg::*;

  // An all-zero register would lock up; fall back to a fixed nonzero value.
  localparam logic [15:0] START = (SEED == 16'h0000) ? 16'h0001 : SEED;

  logic [15:0] state_q;

  assign draw = lfsr_advance(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= START;
    end else if (advance) begin
      state_q <= draw;
    end
  end

endmodule

// File: rtl/csma_slot_timer.sv
module csma_slot_timer #(
  parameter int SLOT_CYCLES = 512,
  parameter int SLOT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] slots,
  input  logic              run,
  output logic              expired
);

  localparam int TICK_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_CYCLES - 1);

  logic [SLOT_W-1:0] left_q;
  logic [TICK_W-1:0] tick_q;

  assign expired = run && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      tick_q <= '0;
    end else if (load) begin
      left_q <= slots;
      tick_q <= '0;
    end else if (run && (left_q != '0)) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/csma_access_fsm.sv
module csma_access_fsm #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W        = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_request,
  input  logic                 tx_done,
  input  logic                 carrier_sense,
  input  logic                 collision,
  input  logic                 backoff_expired,
  output csma_pkg::tx_state_e  state,
  output logic                 tx_enable,
  output logic                 success,
  output logic                 failure,
  output logic                 abort_ev,
  output logic                 finish_ev,
  output logic                 give_up_ev,
  output logic                 backoff_load,
  output logic [CNT_W-1:0]     attempts,
  output logic [CNT_W-1:0]     attempt_next
);
  import csma_pkg::*;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_ATTEMPTS - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             succ_q, fail_q;
  logic             in_xmit;

  assign in_xmit      = (state_q == ST_XMIT);
  assign abort_ev     = in_xmit && collision;
  assign finish_ev    = in_xmit && !collision && tx_done;
  assign give_up_ev   = abort_ev && (cnt_q == LAST_CNT);
  assign backoff_load = abort_ev && !give_up_ev;
  assign attempt_next = cnt_q + 1'b1;

  // Collision pulls the grant combinationally: no edge between sensing and abort.
  assign tx_enable = in_xmit && !collision;
  assign success   = succ_q;
  assign failure   = fail_q;
  assign state     = state_q;
  assign attempts  = cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_request) state_d = carrier_sense ? ST_DEFER : ST_XMIT;
      end
      ST_DEFER: begin
        if (!carrier_sense) state_d = ST_XMIT;
      end
      ST_XMIT: begin
        if (abort_ev)       state_d = give_up_ev ? ST_IDLE : ST_BACKOFF;
        else if (finish_ev) state_d = ST_IDLE;
      end
      ST_BACKOFF: begin
        if (backoff_expired) state_d = carrier_sense ? ST_DEFER : ST_XMIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (finish_ev || give_up_ev) cnt_d = '0;
    else if (abort_ev)           cnt_d = attempt_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      succ_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      succ_q  <= finish_ev;
      fail_q  <= give_up_ev;
    end
  end

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl #(
  parameter int          SLOT_CYCLES  = 512,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          BACKOFF_CAP  = 10,
  parameter logic [15:0] SEED         = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_request,
  input  logic tx_done,
  input  logic carrier_sense,
  input  logic collision,
  output logic tx_enable,
  output logic success,
  output logic failure
);
  import csma_pkg::*;

  localparam int CNT_W  = $clog2(MAX_ATTEMPTS + 1);
  localparam int SLOT_W = BACKOFF_CAP;

  // Named internal events, observed by the bound checker.
  tx_state_e         state;
  logic              abort_ev, finish_ev, give_up_ev, backoff_load;
  logic              backoff_expired, in_backoff;
  logic [CNT_W-1:0]  attempts, attempt_next;
  logic [15:0]       draw, mask;
  logic [SLOT_W-1:0] slots;

  assign in_backoff = (state == ST_BACKOFF);
  assign mask       = window_mask(int'(attempt_next), BACKOFF_CAP);
  assign slots      = draw[SLOT_W-1:0] & mask[SLOT_W-1:0];

  csma_access_fsm #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_request     (tx_request),
    .tx_done        (tx_done),
    .carrier_sense  (carrier_sense),
    .collision      (collision),
    .backoff_expired(backoff_expired),
    .state          (state),
    .tx_enable      (tx_enable),
    .success        (success),
    .failure        (failure),
    .abort_ev       (abort_ev),
    .finish_ev      (finish_ev),
    .give_up_ev     (give_up_ev),
    .backoff_load   (backoff_load),
    .attempts       (attempts),
    .attempt_next   (attempt_next)
  );

  csma_lfsr #(
    .SEED(SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(abort_ev),
    .draw   (draw)
  );

  csma_slot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .SLOT_W     (SLOT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (backoff_load),
    .slots  (slots),
    .run    (in_backoff),
    .expired(backoff_expired)
  );

endmodule

// File: rtl/csma_tx_ctrl_chk.sv
module csma_tx_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             carrier_sense,
  input logic             collision,
  input logic             tx_done,
  input logic             tx_enable,
  input logic             success,
  input logic             failure,
  input logic             in_backoff,
  input logic             abort_ev,
  input logic             give_up_ev,
  input logic [CNT_W-1:0] attempts
);

  assert_grant_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_enable) |-> !$past(carrier_sense));

  assert_abort_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !tx_enable);

  assert_quiet_backoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_backoff |-> !tx_enable);

  assert_fail_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    failure |-> ($past(collision) && ($past(attempts) == CNT_W'(MAX_ATTEMPTS - 1))));

  assert_fail_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    give_up_ev |=> (failure && (attempts == '0)));

  assert_attempt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    attempts < CNT_W'(MAX_ATTEMPTS));

  assert_success_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> ($past(tx_done) && !$past(collision)));

  assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({success, failure}));

endmodule

bind csma_tx_ctrl csma_tx_ctrl_chk #(
  .MAX_ATTEMPTS(MAX_ATTEMPTS),
  .CNT_W       (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .carrier_sense(carrier_sense),
  .collision    (collision),
  .tx_done      (tx_done),
  .tx_enable    (tx_enable),
  .success      (success),
  .failure      (failure),
  .in_backoff   (in_backoff),
  .abort_ev     (abort_ev),
  .give_up_ev   (give_up_ev),
  .attempts     (attempts)
);

// File: tb/csma_tx_ctrl_tb.sv
module csma_tx_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 4;
  localparam int MAXA       = 16;
  localparam int CAP        = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_request = 1'b0;
  logic tx_done = 1'b0;
  logic carrier_sense = 1'b0;
  logic collision = 1'b0;
  logic tx_enable, success, failure;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  int m_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csma_tx_ctrl #(
    .SLOT_CYCLES (SLOT),
    .MAX_ATTEMPTS(MAXA),
    .BACKOFF_CAP (CAP),
    .SEED        (16'hACE1)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_request   (tx_request),
    .tx_done      (tx_done),
    .carrier_sense(carrier_sense),
    .collision    (collision),
    .tx_enable    (tx_enable),
    .success      (success),
    .failure      (failure)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of the shift register: feedback is the parity of the tapped bits.
  function automatic logic [15:0] model_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  task automatic start_req(input string tag);
    tx_request = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_request = 1'b0;
    check(tag, int'(tx_enable), 1);
  endtask

  task automatic finish_ok;
    tx_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_done = 1'b0;
    check("R8 success pulse", int'(success), 1);
    check("R8 grant ends", int'(tx_enable), 0);
    @(negedge clk);
    check("R8 success one cycle", int'(success), 0);
    m_n = 0;
  endtask

  // Called at a falling edge while granted. busy: hold carrier through backoff.
  task automatic collide(input bit with_done, input bit busy);
    int k;
    int cnt;
    bit seen;
    collision = 1'b1;
    tx_done = with_done;
    if (busy) carrier_sense = 1'b1;
    #1;
    check("R4 same-cycle abort", int'(tx_enable), 0);
    m_lfsr = model_step(m_lfsr);
    m_n++;
    if (m_n == MAXA) begin
      @(posedge clk);
      @(negedge clk);
      collision = 1'b0;
      check("R7 failure pulse", int'(failure), 1);
      check("R7 no grant", int'(tx_enable), 0);
      @(negedge clk);
      check("R7 failure one cycle", int'(failure), 0);
      m_n = 0;
      return;
    end
    k = int'(m_lfsr & 16'((1 << ((m_n < CAP) ? m_n : CAP)) - 1));
    if (!busy) begin
      cnt = 0;
      seen = 1'b0;
      for (int i = 0; i < 6000 && !seen; i++) begin
        @(posedge clk);
        cnt++;
        @(negedge clk);
        collision = 1'b0;
        tx_done = 1'b0;
        if (cnt == 1 && with_done) check("R9 collision beats done", int'(success), 0);
        if (tx_enable) seen = 1'b1;
      end
      check("R5 retry edge", cnt, k * SLOT + 2);
    end else begin
      cnt = 0;
      for (int i = 0; i < k * SLOT + 6; i++) begin
        @(posedge clk);
        @(negedge clk);
        collision = 1'b0;
        tx_done = 1'b0;
        if (tx_enable) cnt++;
      end
      check("R6 held off by carrier", cnt, 0);
      carrier_sense = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R6 grant after carrier drops", int'(tx_enable), 1);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 enable in reset", int'(tx_enable), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 enable low", int'(tx_enable), 0);
    check("R1 success low", int'(success), 0);
    check("R1 failure low", int'(failure), 0);
  endtask

  task automatic t_done_idle;
    tx_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_done = 1'b0;
    check("R10 no success from idle", int'(success), 0);
    check("R10 stays idle", int'(tx_enable), 0);
  endtask

  task automatic t_free;
    start_req("R2 immediate grant");
    finish_ok();
  endtask

  task automatic t_defer;
    int hits;
    carrier_sense = 1'b1;
    tx_request = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_request = 1'b0;
    hits = 0;
    for (int i = 0; i < 5; i++) begin
      if (tx_enable) hits++;
      @(negedge clk);
    end
    check("R3 deferred while busy", hits, 0);
    carrier_sense = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 grant after idle medium", int'(tx_enable), 1);
    finish_ok();
  endtask

  task automatic t_backoff_series;
    start_req("R2 grant before collisions");
    collide(1'b0, 1'b0);
    collide(1'b0, 1'b0);
    collide(1'b0, 1'b0);
    finish_ok();
    start_req("R8 grant after clear");
    collide(1'b0, 1'b0);   // count was cleared: window for n = 1
    finish_ok();
  endtask

  task automatic t_busy_end;
    start_req("R2 grant before busy retry");
    collide(1'b0, 1'b1);
    finish_ok();
  endtask

  task automatic t_simul;
    start_req("R2 grant before joint event");
    collide(1'b1, 1'b0);
    finish_ok();
  endtask

  task automatic t_give_up;
    int hits;
    start_req("R2 grant before give-up run");
    for (int i = 0; i < MAXA; i++) collide(1'b0, 1'b0);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      if (tx_enable) hits++;
      @(negedge clk);
    end
    check("R7 no retry after give-up", hits, 0);
    start_req("R7 fresh request after give-up");
    collide(1'b0, 1'b0);
    finish_ok();
  endtask

  initial begin
    t_reset();
    t_done_idle();
    t_free();
    t_defer();
    t_backoff_series();
    t_busy_end();
    t_simul();
    t_give_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule